// File: doc/BRIEF.md
# Collision-Checking Serial Transmitter

This block sends asynchronous frames onto a shared line, such as a single wire or a wired-AND bus, and checks its own output as it goes. Every frame is one start bit, a data word sent least significant bit first, and one stop bit. While a frame is on the line, the block reads the line back through its receive input and compares each sampled level with the level it is driving. Any difference sets a sticky collision flag. The flag stays set until software writes a one to clear it. When the auto-disable option is on, a difference also drops the transmit enable and abandons the frame.

A compare-source option sets when the comparison happens. It is either the bit-rate tick or a strobe pulse from an external timer. A start-source option sets when a frame begins. It is either the first bit tick after the block is ready to send, or an edge on the receive line. The edge is falling for normal polarity and rising for inverted polarity. A polarity option inverts every level on both lines. The bit-rate enable and the strobe pulse come from outside the block.

The controller is a single state machine with five states:
- `ST_IDLE` moves to `ST_ARMED` once the enable is on and a word is pending.
- `ST_ARMED` goes back to `ST_IDLE` if the enable drops. It moves to `ST_START` on its start event, which is either a bit tick or the qualified receive edge.
- `ST_START` moves to `ST_DATA` on the next tick.
- `ST_DATA` moves to `ST_STOP` on the tick that ends the last data bit.
- `ST_STOP` moves to `ST_IDLE` on the next tick.
- An abort from any frame state returns the machine to `ST_IDLE` when a collision occurs with auto-disable on.

Top module: `uart_bc_tx`

## Requirements
- R1: The frame is one start bit at logic 0, then DATA_W data bits with the least significant bit first, then one stop bit at logic 1. Each bit lasts from one `bit_en` tick to the next. Every level on `txd` is XORed with `inv_pol`. The idle level is `1 ^ inv_pol`, and `busy` is 1 only while a start, data or stop bit is being driven.
- R2: With `start_sel`=0, the start bit begins at the first `bit_en` tick that comes after the block became ready to send. Ready means the enable is on and a word written with `wr_data` is pending.
- R3: With `start_sel`=1, ticks alone never start a frame. A frame starts within four clock cycles after `rxd` changes from 1 to 0 when `inv_pol`=0, or from 0 to 1 when `inv_pol`=1.
- R4: With `start_sel`=1, a receive edge that arrives before the block is ready to send is ignored. No frame starts until a later edge arrives.
- R5: With `strobe_sel`=0, the line is compared at each `bit_en` tick during a frame. It is compared against the level being driven, with `rxd` passed through two synchronising flops. A mismatch sets `coll_flag` on the following cycle, and a clean frame leaves it clear.
- R6: With `strobe_sel`=1, the line is compared only on `ext_strobe` pulses during a frame. A mismatch that is present only at `bit_en` ticks does not set the flag.
- R7: `coll_flag` stays set until `coll_clr` is pulsed. A new mismatch in the same cycle as `coll_clr` wins over the clear.
- R8: With `autoclr_en`=1, a mismatch clears `tx_en`, abandons the frame and returns `txd` to idle, all at the same clock edge that sets the flag. `busy` then stays low.
- R9: With `autoclr_en`=0, a mismatch leaves `tx_en` set and the frame runs to its stop bit.
- R10: After reset, `txd` is at the idle level, and `busy`, `tx_en` and `coll_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit-rate tick |
| ext_strobe | input | 1 | External compare strobe, from a timer underflow |
| strobe_sel | input | 1 | 0: compare on `bit_en`; 1: compare on `ext_strobe` |
| autoclr_en | input | 1 | 1: a collision drops the enable and aborts the frame |
| start_sel | input | 1 | 0: start on a tick; 1: start on a receive edge |
| inv_pol | input | 1 | Inverts all line levels and the active start edge |
| tx_en_set | input | 1 | Pulse that sets the transmit enable |
| tx_en_clr | input | 1 | Pulse that clears the transmit enable |
| wr_data | input | 1 | Pulse that writes `data_in` as the pending word |
| data_in | input | DATA_W | Word to send |
| coll_clr | input | 1 | Write-one pulse that clears the collision flag |
| rxd | input | 1 | Line level read back |
| txd | output | 1 | Line drive |
| busy | output | 1 | A frame bit is being driven |
| tx_en | output | 1 | Transmit enable state |
| coll_flag | output | 1 | Sticky collision flag |

## Verification
The assertions check on every cycle that:
- the line sits at idle whenever no frame is active;
- the flag is sticky;
- a rising flag coincides with an active frame and with a pulse on the selected compare source;
- auto-disable drops the enable and `busy` at the edge where the flag rises;
- without auto-disable, only `tx_en_clr` can drop the enable.

Only the bench scenarios can show:
- the bit order and levels of a whole frame under both polarities;
- the tick on which a frame starts;
- that an early receive edge is ignored;
- that a mismatch present only at the unselected compare source goes unflagged.

// File: rtl/uart_bc_pkg.sv
package uart_bc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/uart_bc_sync.sv
// Receive-line synchroniser with polarity-qualified start-edge detection.
module uart_bc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic inv_pol,
    output logic rx_s,
    output logic trig
);
    logic [STAGES-1:0] chain;
    logic              rx_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= rxd;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign rx_s = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx_s;
    end

    // falling edge for normal lines, rising edge for inverted lines
    assign trig = inv_pol ? (rx_s & ~rx_prev) : (~rx_s & rx_prev);
endmodule

// File: rtl/uart_bc_cmp.sv
// Driven-versus-sampled comparison and sticky collision flag.
module uart_bc_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic in_frame,
    input  logic bit_en,
    input  logic ext_strobe,
    input  logic strobe_sel,
    input  logic rx_s,
    input  logic txd_lvl,
    input  logic coll_clr,
    output logic collide,
    output logic coll_flag
);
    logic sample;

    assign sample  = strobe_sel ? ext_strobe : bit_en;
    assign collide = in_frame && sample && (rx_s != txd_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        coll_flag <= 1'b0;
        else if (collide)  coll_flag <= 1'b1;
        else if (coll_clr) coll_flag <= 1'b0;
    end
endmodule

// File: rtl/uart_bc_fsm.sv
// Frame sequencer: enable, pending word, shift register and line drive.
module uart_bc_fsm
    import uart_bc_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              start_sel,
    input  logic              inv_pol,
    input  logic              autoclr_en,
    input  logic              trig,
    input  logic              collide,
    input  logic              tx_en_set,
    input  logic              tx_en_clr,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_in,
    output logic              txd,
    output logic              busy,
    output logic              tx_en
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] hold;
    logic              pend;
    logic              abort;
    logic              launch;
    logic              go_event;

    assign abort    = collide && autoclr_en;
    assign go_event = start_sel ? trig : bit_en;
    assign launch   = (state == ST_ARMED) && tx_en && go_event && !abort;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_en && pend)          state_nx = ST_ARMED;
            ST_ARMED: if (!tx_en)                 state_nx = ST_IDLE;
                      else if (go_event)          state_nx = ST_START;
            ST_START: if (bit_en)                 state_nx = ST_DATA;
            ST_DATA:  if (bit_en && cnt == LAST_BIT) state_nx = ST_STOP;
            ST_STOP:  if (bit_en)                 state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
        if (abort) state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            hold  <= '0;
            pend  <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            if (launch) begin
                shreg <= hold;
                pend  <= 1'b0;
                cnt   <= '0;
            end else if (state == ST_DATA && bit_en) begin
                shreg <= shreg >> 1;
                cnt   <= cnt + 1'b1;
            end
            if (wr_data) begin
                hold <= data_in;
                pend <= 1'b1;
            end
            if (abort || tx_en_clr) tx_en <= 1'b0;
            else if (tx_en_set)     tx_en <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        txd  = ~inv_pol;
        unique case (state)
            ST_IDLE, ST_ARMED: begin
                busy = 1'b0;
                txd  = ~inv_pol;
            end
            ST_START: begin
                busy = 1'b1;
                txd  = inv_pol;
            end
            ST_DATA: begin
                busy = 1'b1;
                txd  = shreg[0] ^ inv_pol;
            end
            ST_STOP: begin
                busy = 1'b1;
                txd  = ~inv_pol;
            end
            default: begin
                busy = 1'b0;
                txd  = ~inv_pol;
            end
        endcase
    end
endmodule

// File: rtl/uart_bc_tx.sv
// Top: serial transmitter with read-back collision detection.
module uart_bc_tx #(
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ext_strobe,
    input  logic              strobe_sel,
    input  logic              autoclr_en,
    input  logic              start_sel,
    input  logic              inv_pol,
    input  logic              tx_en_set,
    input  logic              tx_en_clr,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              coll_clr,
    input  logic              rxd,
    output logic              txd,
    output logic              busy,
    output logic              tx_en,
    output logic              coll_flag
);
    logic rx_s;
    logic trig;
    logic collide;

    uart_bc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .inv_pol (inv_pol),
        .rx_s    (rx_s),
        .trig    (trig)
    );

    uart_bc_cmp u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_frame   (busy),
        .bit_en     (bit_en),
        .ext_strobe (ext_strobe),
        .strobe_sel (strobe_sel),
        .rx_s       (rx_s),
        .txd_lvl    (txd),
        .coll_clr   (coll_clr),
        .collide    (collide),
        .coll_flag  (coll_flag)
    );

    uart_bc_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .start_sel  (start_sel),
        .inv_pol    (inv_pol),
        .autoclr_en (autoclr_en),
        .trig       (trig),
        .collide    (collide),
        .tx_en_set  (tx_en_set),
        .tx_en_clr  (tx_en_clr),
        .wr_data    (wr_data),
        .data_in    (data_in),
        .txd        (txd),
        .busy       (busy),
        .tx_en      (tx_en)
    );
endmodule

// File: rtl/uart_bc_tx_chk.sv
// Property checker bound to the transmitter top.
module uart_bc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic ext_strobe,
    input logic strobe_sel,
    input logic autoclr_en,
    input logic inv_pol,
    input logic tx_en_clr,
    input logic coll_clr,
    input logic txd,
    input logic busy,
    input logic tx_en,
    input logic coll_flag
);
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd == ~inv_pol));

    assert_flag_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(busy));

    assert_tick_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(coll_flag) && !$past(strobe_sel)) |-> $past(bit_en));

    assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(coll_flag) && $past(strobe_sel)) |-> $past(ext_strobe));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(coll_flag) && !$past(coll_clr)) |-> coll_flag);

    assert_autoclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(coll_flag) && $past(autoclr_en)) |-> (!tx_en && !busy));

    assert_keep_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_en) && !$past(autoclr_en) && !$past(tx_en_clr)) |-> tx_en);
endmodule

bind uart_bc_tx uart_bc_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .ext_strobe (ext_strobe),
    .strobe_sel (strobe_sel),
    .autoclr_en (autoclr_en),
    .inv_pol    (inv_pol),
    .tx_en_clr  (tx_en_clr),
    .coll_clr   (coll_clr),
    .txd        (txd),
    .busy       (busy),
    .tx_en      (tx_en),
    .coll_flag  (coll_flag)
);

// File: tb/tb_uart_bc_tx.sv
module tb_uart_bc_tx;
    localparam int DW = 9;
    localparam int NBITS = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] divcnt = '0;
    logic bit_en;
    logic ext_strobe = 1'b0;
    logic strobe_sel = 1'b0;
    logic autoclr_en = 1'b0;
    logic start_sel = 1'b0;
    logic inv_pol = 1'b0;
    logic tx_en_set = 1'b0;
    logic tx_en_clr = 1'b0;
    logic wr_data = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic coll_clr = 1'b0;
    logic rxd;
    logic txd, busy, tx_en, coll_flag;
    logic jam_en = 1'b0;
    logic edge_en = 1'b0;
    logic edge_val = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        divcnt <= divcnt + 3'd1;
        cycles <= cycles + 1;
    end
    assign bit_en = (divcnt == 3'd7);
    assign rxd = edge_en ? edge_val : (jam_en ? ~txd : txd);

    uart_bc_tx #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ext_strobe(ext_strobe),
        .strobe_sel(strobe_sel), .autoclr_en(autoclr_en), .start_sel(start_sel),
        .inv_pol(inv_pol), .tx_en_set(tx_en_set), .tx_en_clr(tx_en_clr),
        .wr_data(wr_data), .data_in(data_in), .coll_clr(coll_clr), .rxd(rxd),
        .txd(txd), .busy(busy), .tx_en(tx_en), .coll_flag(coll_flag)
    );

    function automatic logic exp_bit(input logic [DW-1:0] d, input int idx, input logic inv);
        if (idx == 0) return inv;
        if (idx == NBITS - 1) return ~inv;
        return d[idx-1] ^ inv;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_div(input logic [2:0] n);
        do @(negedge clk); while (divcnt != n);
    endtask

    task automatic pulse_en_set();
        tx_en_set = 1'b1; @(negedge clk); tx_en_set = 1'b0;
    endtask

    task automatic load(input logic [DW-1:0] d);
        data_in = d; wr_data = 1'b1; @(negedge clk); wr_data = 1'b0;
    endtask

    task automatic pulse_clr();
        coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
    endtask

    // Collect the bit levels driven at each tick that ends a frame bit.
    task automatic capture(input logic [DW-1:0] d, input logic inv, input string req);
        int got = 0;
        int guard = 0;
        logic ok = 1'b1;
        while (got < NBITS && guard < 400) begin
            if (bit_en && busy) begin
                if (txd !== exp_bit(d, got, inv)) ok = 1'b0;
                got++;
            end
            guard++;
            @(negedge clk);
        end
        checks++;
        if (!ok || got != NBITS) begin
            fails++;
            $display("FAIL %s: frame of %h inv %b actual bits %0d ok %b expected %0d ok 1",
                     req, d, inv, got, ok, NBITS);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 400) begin @(negedge clk); g++; end
    endtask

    // Start a frame in tick mode and check its start timing (R2).
    task automatic tick_frame(input logic [DW-1:0] d, input logic inv);
        inv_pol = inv;
        wait_div(3'd1);
        load(d);
        wait_div(3'd7);
        chk("R2 armed not busy before tick", busy, 1'b0);
        @(negedge clk);
        chk("R2 busy after first tick", busy, 1'b1);
        chk("R1 start level", txd, inv);
        capture(d, inv, "R1");
        @(negedge clk);
        chk("R1 busy low after stop", busy, 1'b0);
        chk("R1 idle level", txd, ~inv);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        chk("R10 txd idle", txd, 1'b1);
        chk("R10 busy", busy, 1'b0);
        chk("R10 tx_en", tx_en, 1'b0);
        chk("R10 flag", coll_flag, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed frames in tick-start mode
        pulse_en_set();
        chk("R2 enable set", tx_en, 1'b1);
        tick_frame(9'h1A5, 1'b0);
        tick_frame(9'h000, 1'b0);
        tick_frame(9'h1FF, 1'b1);
        chk("R5 clean frames no flag", coll_flag, 1'b0);

        // random frames
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 8; i++) begin
            rd = DW'($urandom);
            tick_frame(rd, 1'($urandom));
        end
        inv_pol = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 random frames no flag", coll_flag, 1'b0);

        // R3 / R4: edge start mode
        start_sel = 1'b1;
        tx_en_clr = 1'b1; @(negedge clk); tx_en_clr = 1'b0;
        wait_div(3'd0);
        edge_val = 1'b0; edge_en = 1'b1;
        repeat (5) @(negedge clk);
        edge_en = 1'b0;
        repeat (4) @(negedge clk);
        load(9'h0F3);
        pulse_en_set();
        repeat (30) @(negedge clk);
        chk("R4 early edge ignored", busy, 1'b0);
        chk("R3 ticks alone do not start", txd, 1'b1);
        wait_div(3'd0);
        edge_val = 1'b0; edge_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 falling edge starts frame", busy, 1'b1);
        edge_en = 1'b0;
        capture(9'h0F3, 1'b0, "R3 frame");
        wait_idle();

        // inverted polarity: rising edge triggers
        inv_pol = 1'b1;
        repeat (6) @(negedge clk);
        load(9'h15A);
        repeat (20) @(negedge clk);
        chk("R3 inverted idle no start", busy, 1'b0);
        wait_div(3'd0);
        edge_val = 1'b1; edge_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 rising edge starts inverted frame", busy, 1'b1);
        edge_en = 1'b0;
        capture(9'h15A, 1'b1, "R3 inverted frame");
        wait_idle();
        inv_pol = 1'b0;
        start_sel = 1'b0;
        repeat (6) @(negedge clk);

        // R5 / R9: tick-compare collision without auto-disable
        wait_div(3'd1);
        load(9'h0AA);
        wait_div(3'd0);
        wait_div(3'd0);
        wait_div(3'd1);
        jam_en = 1'b1;
        wait_div(3'd1);
        jam_en = 1'b0;
        chk("R5 mismatch at tick sets flag", coll_flag, 1'b1);
        chk("R9 enable kept", tx_en, 1'b1);
        chk("R9 frame continues", busy, 1'b1);
        wait_idle();
        chk("R7 flag sticky after frame", coll_flag, 1'b1);
        pulse_clr();
        chk("R7 flag cleared by write-one", coll_flag, 1'b0);

        // R6: strobe-compare mode
        strobe_sel = 1'b1;
        wait_div(3'd1);
        load(9'h133);
        wait_div(3'd0);
        wait_div(3'd0);
        wait_div(3'd1);
        jam_en = 1'b1;
        wait_div(3'd1);
        jam_en = 1'b0;
        chk("R6 tick ignored in strobe mode", coll_flag, 1'b0);
        wait_div(3'd2);
        jam_en = 1'b1;
        wait_div(3'd5);
        ext_strobe = 1'b1; @(negedge clk); ext_strobe = 1'b0;
        jam_en = 1'b0;
        chk("R6 strobe mismatch sets flag", coll_flag, 1'b1);
        wait_idle();
        pulse_clr();
        strobe_sel = 1'b0;

        // R8: auto-disable abort
        autoclr_en = 1'b1;
        wait_div(3'd1);
        load(9'h0FF);
        wait_div(3'd0);
        wait_div(3'd0);
        wait_div(3'd1);
        jam_en = 1'b1;
        wait_div(3'd7);
        @(negedge clk);
        jam_en = 1'b0;
        chk("R8 flag set", coll_flag, 1'b1);
        chk("R8 enable cleared", tx_en, 1'b0);
        chk("R8 frame aborted", busy, 1'b0);
        chk("R8 line idle", txd, 1'b1);
        load(9'h001);
        repeat (40) @(negedge clk);
        chk("R8 no restart while disabled", busy, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule